// File: doc/BRIEF.md
# Carry-Save Result Queue with Binary Conversion

This block sits on the return path of a pipelined modular multiplier kernel. The last processing stage delivers each result word as a redundant pair: a sum vector and a carry vector whose arithmetic total is the true value. The first stage may be ready to take that word at once. If it is not, the word has to wait.

Waiting words are reduced to plain binary by a ripple carry-propagate adder before they enter a FIFO. Each stored entry is therefore W bits wide instead of 2W. The carry out of one converted word is held in a register and added into the next converted word of the same operand. When the FIFO is empty and the consumer is ready, the redundant pair passes straight through and skips the adder.

A three-way output selector picks one of three sources: forced zero on the first cycle of an operation, the bypassed pair, or the oldest queued word presented with a zero carry vector. Each converted binary word is also exported on a registered side output.

Top module: `csq_queue`

## Requirements
- R1: After reset the queue reports empty=1, full=0 and overflow=0. nr_valid is 0, and out_valid is 0 while cons_ready and cons_start are low.
- R2: While cons_start is 1, out_valid=1, out_src=0 (zero), and out_sum and out_carry are all zeros. No entry is removed from the queue, and an incoming word is converted and queued.
- R3: When cons_start=0, cons_ready=1, the queue is empty and in_valid=1, the outputs are out_src=1 (bypass), out_sum=in_sum and out_carry=in_carry in the same cycle. The word is not queued.
- R4: Every word that is not bypassed is converted to (in_sum + in_carry + cin) mod 2^W. Here cin is 0 when in_first=1; otherwise it is the carry out of bit W-1 of the previous converted word.
- R5: When cons_start=0, cons_ready=1 and the queue holds entries, the outputs are out_src=2 (queue), out_sum equal to the oldest entry and out_carry=0. That entry is removed at the clock edge, so entries leave in arrival order.
- R6: When cons_start=0 and cons_ready=0, and also when the queue is empty with no incoming word, out_valid=0 and out_sum and out_carry are zero.
- R7: One cycle after each conversion, nr_valid=1 and nr_word holds the converted word. nr_valid is 0 after a cycle with no conversion.
- R8: full becomes 1 when DEPTH entries are held. empty becomes 1 once the last entry is removed.
- R9: A conversion while the queue is full and no entry is removed sets overflow, which stays 1 until reset. The word is dropped and the stored entries are unchanged.
- R10: While the queue is full, a conversion in the same cycle as a removal is accepted, and full stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming carry-save word present |
| in_first | input | 1 | Incoming word is the lowest word of an operand |
| in_sum | input | W | Sum vector of the incoming word |
| in_carry | input | W | Carry vector of the incoming word |
| cons_start | input | 1 | First cycle of an operation at the consumer; forces zero |
| cons_ready | input | 1 | Consumer stage can take a word |
| out_valid | output | 1 | Word presented to the consumer |
| out_src | output | 2 | Selected source: 0 zero, 1 bypass, 2 queue |
| out_sum | output | W | Sum vector to the consumer |
| out_carry | output | W | Carry vector to the consumer |
| nr_valid | output | 1 | Converted binary word available |
| nr_word | output | W | Converted binary word |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entry |
| q_overflow | output | 1 | Sticky: a word was dropped on a full queue |

## Verification
A wrong inter-word carry register changes the first queued word that follows, because that word arrives at the consumer off by one. A queued pair that was not converted correctly would likewise show a wrong out_sum as soon as it is dequeued. A corrupted read or write pointer appears as words leaving out of order, or with stale values, on the drain that follows. A bad occupancy count shows at once in the full and empty flags. A wrong selector state shows in the same cycle as a wrong out_src or a nonzero out_carry on a queued word. The sweeps pass every sum and carry pair through both the bypass path and the converting path, and they drain after each push so that every such fault surfaces within a cycle or two.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_QUEUE  = 2'd2
    } csq_src_e;

endpackage

// File: rtl/csq_cpa.sv
module csq_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];

endmodule

// File: rtl/csq_fifo.sv
module csq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign rdata   = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
        end
        if (pop_ok) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R8
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> !empty);

    // R8
    last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == CW'(1)) |=> empty);

endmodule

// File: rtl/csq_sel.sv
module csq_sel
    import csq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ready,
    input  logic         in_valid,
    input  logic [W-1:0] in_sum,
    input  logic [W-1:0] in_carry,
    input  logic         q_empty,
    input  logic [W-1:0] q_data,
    output csq_src_e     sel,
    output logic         out_valid,
    output logic [W-1:0] out_sum,
    output logic [W-1:0] out_carry,
    output logic         pop,
    output logic         bypass
);
    always_comb begin
        sel       = SRC_ZERO;
        out_valid = 1'b0;
        out_sum   = '0;
        out_carry = '0;
        pop       = 1'b0;
        bypass    = 1'b0;
        if (start) begin
            out_valid = 1'b1;
        end else if (ready) begin
            if (!q_empty) begin
                sel       = SRC_QUEUE;
                out_valid = 1'b1;
                out_sum   = q_data;
                pop       = 1'b1;
            end else if (in_valid) begin
                sel       = SRC_BYPASS;
                out_valid = 1'b1;
                out_sum   = in_sum;
                out_carry = in_carry;
                bypass    = 1'b1;
            end
        end
    end

    // R5
    queue_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_QUEUE) |-> !q_empty);

endmodule

// File: rtl/csq_queue.sv
module csq_queue
    import csq_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_first,
    input  logic [W-1:0] in_sum,
    input  logic [W-1:0] in_carry,
    input  logic         cons_start,
    input  logic         cons_ready,
    output logic         out_valid,
    output logic [1:0]   out_src,
    output logic [W-1:0] out_sum,
    output logic [W-1:0] out_carry,
    output logic         nr_valid,
    output logic [W-1:0] nr_word,
    output logic         q_full,
    output logic         q_empty,
    output logic         q_overflow
);
    typedef struct packed {
        logic         cin;
        logic         ovf;
        logic         nr_v;
        logic [W-1:0] nr_w;
    } top_st_t;

    top_st_t st_d, st_q;

    csq_src_e     sel;
    logic         pop, bypass, convert;
    logic [W-1:0] q_data, cpa_sum;
    logic         cpa_cout, cpa_cin;

    assign convert = in_valid && !bypass;
    assign cpa_cin = in_first ? 1'b0 : st_q.cin;

    csq_cpa #(.W(W)) u_cpa (
        .a    (in_sum),
        .b    (in_carry),
        .cin  (cpa_cin),
        .sum  (cpa_sum),
        .cout (cpa_cout)
    );

    csq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (convert),
        .pop   (pop),
        .wdata (cpa_sum),
        .rdata (q_data),
        .full  (q_full),
        .empty (q_empty)
    );

    csq_sel #(.W(W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cons_start),
        .ready     (cons_ready),
        .in_valid  (in_valid),
        .in_sum    (in_sum),
        .in_carry  (in_carry),
        .q_empty   (q_empty),
        .q_data    (q_data),
        .sel       (sel),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_carry (out_carry),
        .pop       (pop),
        .bypass    (bypass)
    );

    assign out_src = sel;

    always_comb begin
        st_d      = st_q;
        st_d.nr_v = convert;
        if (convert) begin
            st_d.nr_w = cpa_sum;
            st_d.cin  = cpa_cout;
            if (q_full && !pop) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nr_valid   = st_q.nr_v;
    assign nr_word    = st_q.nr_w;
    assign q_overflow = st_q.ovf;

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_overflow |=> q_overflow);

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_full && !cons_ready) |=> q_overflow);

    // R7
    export_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nr_valid |-> $past(in_valid));

    // R3
    bypass_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_src == 2'd1) |=> q_empty);

    // R2
    start_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_start && !q_empty) |=> !q_empty);

    // R5
    queue_carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_src == 2'd2) |-> (out_carry == '0));

endmodule

// File: tb/tb_csq_queue.sv
`timescale 1ns/1ps
module tb_csq_queue;
    localparam int W = 4;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_first = 0, cons_start = 0, cons_ready = 0;
    logic [W-1:0] in_sum = '0, in_carry = '0;
    logic out_valid, nr_valid, q_full, q_empty, q_overflow;
    logic [1:0] out_src;
    logic [W-1:0] out_sum, out_carry, nr_word;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    csq_queue #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_sum(in_sum), .in_carry(in_carry), .cons_start(cons_start),
        .cons_ready(cons_ready), .out_valid(out_valid), .out_src(out_src),
        .out_sum(out_sum), .out_carry(out_carry), .nr_valid(nr_valid),
        .nr_word(nr_word), .q_full(q_full), .q_empty(q_empty),
        .q_overflow(q_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input bit f, input int s, input int c,
                         input bit st, input bit rd);
        in_valid = v; in_first = f; in_sum = W'(s); in_carry = W'(c);
        cons_start = st; cons_ready = rd;
        #0.5;
    endtask

    initial begin
        int cin;
        int word;
        int e;
        int exp_q[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 empty", q_empty, 1);
        chk("R1 full", q_full, 0);
        chk("R1 overflow", q_overflow, 0);
        chk("R1 nr_valid", nr_valid, 0);
        chk("R1 out_valid", out_valid, 0);
        @(negedge clk);

        // R3 bypass sweep over every pair
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                drive(1, 0, s, c, 0, 1);
                chk("R3 src", out_src, 1);
                chk("R3 sum", out_sum, s);
                chk("R3 carry", out_carry, c);
                chk("R3 valid", out_valid, 1);
                cyc();
                chk("R3 not queued", q_empty, 1);
                chk("R7 no export on bypass", nr_valid, 0);
            end
        end

        // R4 R5 R7 conversion sweep with carry chaining
        cin = 0;
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                bit f;
                f = ((s + c) % 3) == 0;
                drive(1, f, s, c, 0, 0);
                chk("R6 idle valid", out_valid, 0);
                chk("R6 idle sum", out_sum, 0);
                e = s + c + (f ? 0 : cin);
                word = e % 16;
                cin = e / 16;
                cyc();
                chk("R7 nr_valid", nr_valid, 1);
                chk("R4 nr_word", nr_word, word);
                chk("R8 not empty", q_empty, 0);
                drive(0, 0, 0, 0, 0, 1);
                chk("R5 src", out_src, 2);
                chk("R5 sum", out_sum, word);
                chk("R5 carry", out_carry, 0);
                cyc();
                chk("R8 empty after pop", q_empty, 1);
                chk("R7 nr_valid low", nr_valid, 0);
            end
        end

        // R2 zero selection on start
        drive(1, 1, 3, 4, 1, 1);
        chk("R2 valid", out_valid, 1);
        chk("R2 src", out_src, 0);
        chk("R2 sum", out_sum, 0);
        chk("R2 carry", out_carry, 0);
        cyc();
        chk("R2 queued", q_empty, 0);
        chk("R2 nr_word", nr_word, 7);
        drive(0, 0, 0, 0, 1, 1);
        chk("R2 src hold", out_src, 0);
        cyc();
        chk("R2 no pop", q_empty, 0);
        drive(0, 0, 0, 0, 0, 0);
        chk("R6 valid", out_valid, 0);
        chk("R6 sum", out_sum, 0);
        drive(0, 0, 0, 0, 0, 1);
        chk("R5 src after start", out_src, 2);
        chk("R5 sum after start", out_sum, 7);
        cyc();
        chk("R8 empty", q_empty, 1);

        // R8 R9 R10 fill, overflow, push with pop
        for (int k = 1; k <= DEPTH; k++) begin
            drive(1, 1, k, 0, 0, 0);
            cyc();
            chk("R8 full", q_full, (k == DEPTH) ? 1 : 0);
            exp_q.push_back(k);
        end
        chk("R9 no overflow yet", q_overflow, 0);
        drive(1, 1, 9, 0, 0, 0);
        cyc();
        chk("R9 overflow", q_overflow, 1);
        chk("R9 still full", q_full, 1);
        drive(1, 1, 10, 0, 0, 1);
        chk("R10 head", out_sum, exp_q.pop_front());
        exp_q.push_back(10);
        cyc();
        chk("R10 full kept", q_full, 1);
        chk("R9 sticky", q_overflow, 1);
        while (exp_q.size() > 0) begin
            drive(0, 0, 0, 0, 0, 1);
            chk("R5 order", out_sum, exp_q.pop_front());
            chk("R5 src drain", out_src, 2);
            cyc();
        end
        chk("R8 drained empty", q_empty, 1);
        chk("R8 drained not full", q_full, 0);
        chk("R9 sticky end", q_overflow, 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule